// File: doc/BRIEF.md
# Machine-Mode CSR and Trap Control Unit

This unit holds the small set of machine-mode control and status registers that a compact 32-bit processor core needs to take traps and return from them. The core presents a 12-bit register address, an access operation (replace, bit-set or bit-clear, each with or without a read), and an operand. The unit answers in the same cycle with the previous register value and a flag that marks the access as illegal. Any accepted write lands at the next rising clock edge.

Only a few fields are stored: the scratch register, the exception PC, the trap cause, the trap vector base, the global and previous interrupt-enable bits, and the external interrupt enable. The privilege field in the status register always reads as machine mode. Every other architectural address belongs to one of three groups. Identification registers read as zero and fault on any write. Counter, event and information registers read as zero and drop writes without a fault. All other addresses, listed or not, fault on every access.

A trap-entry strobe saves the faulting PC and the cause and disables interrupts. A return strobe restores the interrupt enable. The unit exports the handler address, the return PC, and an interrupt-pending flag that the core can poll. The update logic is a small event selector with four named events: EV_IDLE (nothing changes), EV_CSR (a legal write to a stored field), EV_MRET (return from trap) and EV_TRAP (trap entry). When strobes coincide, EV_TRAP beats EV_MRET, and EV_MRET beats EV_CSR.

Top module: `mtrap_csr`

## Requirements
- R1: After reset, the status register reads 0x0000_1800, and the scratch, exception-PC, cause, vector and enable registers all read 0. The pending flag is 0.
- R2: `csr_op` encodes 00 = no access, 01 = replace, 10 = bit-set, 11 = bit-clear. For a legal access with `csr_rd`=1, `rdata` is the register value from before the write; otherwise `rdata` is 0. An accepted write is visible from the next clock edge.
- R3: A bit-set or bit-clear with an all-zero operand performs no write. It therefore never faults on the write-faulting group, and it leaves stored values unchanged.
- R4: The status register (0x300) holds MIE in bit 3 and MPIE in bit 7, with bits 12:11 fixed at 11 and all other bits reading 0. The enable register (0x304) holds only its bit 11.
- R5: Bit 11 of the pending register (0x344) reads the `ext_irq` input in the same cycle. Writes to 0x344 are dropped without a fault.
- R6: The vector register (0x305) stores bits 31:2, and its bits 1:0 always read 0 (direct mode only). `trap_vec` equals its value.
- R7: The exception-PC register (0x341) stores bits 31:2, and its bits 1:0 read 0. `ret_pc` equals its value.
- R8: The cause register (0x342) accepts only 0, 2, 3, 4, 6, 11 and 0x8000_000B. A write of any other value leaves it unchanged.
- R9: Addresses 0xF11 to 0xF15 read as 0 and raise `illegal` whenever a write would occur.
- R10: Addresses 0x301, 0x310, 0x320, 0x323 to 0x33F, 0x343, 0xB00, 0xB02 and 0xB03 to 0xB1F read as 0 and drop writes without a fault.
- R11: Any other address raises `illegal` on every access with `csr_op` not equal to 00. An illegal access returns `rdata` 0 and changes no state.
- R12: On `trap_take`, the next cycle shows the exception PC equal to `trap_pc` with bits 1:0 cleared, and the cause equal to {`trap_irq`, 27'b0, `trap_code`}. MPIE takes the old MIE and MIE clears. A CSR write or `mret_take` in the same cycle is discarded.
- R13: On `mret_take` without `trap_take`, the next cycle shows MIE equal to the old MPIE and MPIE equal to 1. A CSR write in the same cycle is discarded.
- R14: `irq_pending` is `ext_irq` AND the enable bit 11 AND the status MIE, with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_addr | input | 12 | Register address |
| csr_op | input | 2 | Access operation (R2 encoding) |
| csr_rd | input | 1 | Return the old value on `rdata` |
| csr_wdata | input | 32 | Write, set or clear operand |
| ext_irq | input | 1 | External interrupt level |
| trap_take | input | 1 | Trap-entry strobe |
| trap_irq | input | 1 | Trap is an interrupt (cause bit 31) |
| trap_code | input | 4 | Exception or interrupt code |
| trap_pc | input | 32 | PC of the trapping instruction |
| mret_take | input | 1 | Return-from-trap strobe |
| rdata | output | 32 | Old register value |
| illegal | output | 1 | Access is illegal |
| irq_pending | output | 1 | Enabled external interrupt is pending |
| trap_vec | output | 32 | Handler address |
| ret_pc | output | 32 | Return address |

## Verification
Three results are combinational in the access cycle: `rdata`, `illegal` and `irq_pending`. Every register update, whether from a write, a trap or a return, appears only after the following rising edge. The bench therefore drives each access just after a falling edge and samples the combinational outputs 1 ns later, before the committing edge. Each write is then confirmed by a read in a later cycle. Trap and return effects are checked one edge after their strobe, and the checker properties look exactly one cycle past each strobe.

// File: rtl/mtrap_pkg.sv
package mtrap_pkg;
    localparam int XLEN    = 32;
    localparam int AW      = 12;
    localparam int CODE_W  = 4;

    // bit positions that software and the core decode
    localparam int B_MIE   = 3;
    localparam int B_MPIE  = 7;
    localparam int B_MPP_L = 11;
    localparam int B_MPP_H = 12;
    localparam int B_MEX   = 11;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_RW   = 2'b01,
        OP_SET  = 2'b10,
        OP_CLR  = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        CL_STORED,
        CL_RO_WFAULT,
        CL_RO_QUIET,
        CL_BAD
    } acc_class_e;

    typedef enum logic [2:0] {
        SEL_ZERO,
        SEL_STATUS,
        SEL_IE,
        SEL_IP,
        SEL_TVEC,
        SEL_SCRATCH,
        SEL_EPC,
        SEL_CAUSE
    } reg_sel_e;

    typedef enum logic [1:0] {
        EV_IDLE,
        EV_CSR,
        EV_MRET,
        EV_TRAP
    } upd_ev_e;

    function automatic logic cause_ok(input logic [XLEN-1:0] v);
        logic mid_zero;
        mid_zero = (v[XLEN-2:CODE_W] == '0);
        if (!mid_zero) return 1'b0;
        if (v[XLEN-1]) return (v[CODE_W-1:0] == 4'd11);
        case (v[CODE_W-1:0])
            4'd0, 4'd2, 4'd3, 4'd4, 4'd6, 4'd11: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/mtrap_decode.sv
module mtrap_decode
    import mtrap_pkg::*;
(
    input  logic [AW-1:0] addr,
    output acc_class_e    cls,
    output reg_sel_e      sel
);
    always_comb begin
        cls = CL_BAD;
        sel = SEL_ZERO;
        case (addr) inside
            12'h300: begin cls = CL_STORED;   sel = SEL_STATUS;  end
            12'h304: begin cls = CL_STORED;   sel = SEL_IE;      end
            12'h305: begin cls = CL_STORED;   sel = SEL_TVEC;    end
            12'h340: begin cls = CL_STORED;   sel = SEL_SCRATCH; end
            12'h341: begin cls = CL_STORED;   sel = SEL_EPC;     end
            12'h342: begin cls = CL_STORED;   sel = SEL_CAUSE;   end
            12'h344: begin cls = CL_RO_QUIET; sel = SEL_IP;      end
            [12'hF11:12'hF15]:  cls = CL_RO_WFAULT;
            12'h301, 12'h310, 12'h320, 12'h343,
            12'hB00, 12'hB02,
            [12'h323:12'h33F],
            [12'hB03:12'hB1F]:  cls = CL_RO_QUIET;
            default:            cls = CL_BAD;
        endcase
    end
endmodule

// File: rtl/mtrap_status.sv
module mtrap_status
    import mtrap_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  upd_ev_e         ev,
    input  reg_sel_e        sel,
    input  logic [XLEN-1:0] wval,
    output logic            mie_q,
    output logic            mpie_q,
    output logic            meie_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mie_q  <= 1'b0;
            mpie_q <= 1'b0;
            meie_q <= 1'b0;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    mpie_q <= mie_q;
                    mie_q  <= 1'b0;
                end
                EV_MRET: begin
                    mie_q  <= mpie_q;
                    mpie_q <= 1'b1;
                end
                EV_CSR: begin
                    if (sel == SEL_STATUS) begin
                        mie_q  <= wval[B_MIE];
                        mpie_q <= wval[B_MPIE];
                    end
                    if (sel == SEL_IE) meie_q <= wval[B_MEX];
                end
                EV_IDLE: ;
            endcase
        end
    end
endmodule

// File: rtl/mtrap_store.sv
module mtrap_store
    import mtrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  upd_ev_e           ev,
    input  reg_sel_e          sel,
    input  logic [XLEN-1:0]   wval,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    output logic [XLEN-1:0]   scratch_q,
    output logic [XLEN-3:0]   epc_q,
    output logic [XLEN-3:0]   tvec_q,
    output logic              cause_irq_q,
    output logic [CODE_W-1:0] cause_code_q
);
    logic unused_low_bits;
    assign unused_low_bits = ^{trap_pc[1:0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scratch_q    <= '0;
            epc_q        <= '0;
            tvec_q       <= '0;
            cause_irq_q  <= 1'b0;
            cause_code_q <= '0;
        end else begin
            unique case (ev)
                EV_TRAP: begin
                    epc_q        <= trap_pc[XLEN-1:2];
                    cause_irq_q  <= trap_irq;
                    cause_code_q <= trap_code;
                end
                EV_CSR: begin
                    unique case (sel)
                        SEL_SCRATCH: scratch_q <= wval;
                        SEL_EPC:     epc_q     <= wval[XLEN-1:2];
                        SEL_TVEC:    tvec_q    <= wval[XLEN-1:2];
                        SEL_CAUSE: begin
                            if (cause_ok(wval)) begin
                                cause_irq_q  <= wval[XLEN-1];
                                cause_code_q <= wval[CODE_W-1:0];
                            end
                        end
                        default: ;
                    endcase
                end
                EV_MRET, EV_IDLE: ;
            endcase
        end
    end
endmodule

// File: rtl/mtrap_csr.sv
module mtrap_csr
    import mtrap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     csr_addr,
    input  logic [1:0]        csr_op,
    input  logic              csr_rd,
    input  logic [XLEN-1:0]   csr_wdata,
    input  logic              ext_irq,
    input  logic              trap_take,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic [XLEN-1:0]   trap_pc,
    input  logic              mret_take,
    output logic [XLEN-1:0]   rdata,
    output logic              illegal,
    output logic              irq_pending,
    output logic [XLEN-1:0]   trap_vec,
    output logic [XLEN-1:0]   ret_pc
);
    acc_class_e        cls;
    reg_sel_e          sel;
    csr_op_e           op;
    upd_ev_e           ev;
    logic              access, wants_wr, csr_wr;
    logic [XLEN-1:0]   old_val, wval;
    logic              sts_mie, sts_mpie, ie_mex;
    logic [XLEN-1:0]   scratch_q;
    logic [XLEN-3:0]   epc_q, tvec_q;
    logic              cause_irq_q;
    logic [CODE_W-1:0] cause_code_q;

    assign op = csr_op_e'(csr_op);

    mtrap_decode u_dec (
        .addr (csr_addr),
        .cls  (cls),
        .sel  (sel)
    );

    // legality
    assign access   = (op != OP_NONE);
    assign wants_wr = access && ((op == OP_RW) || (csr_wdata != '0));
    assign illegal  = access && ((cls == CL_BAD) ||
                                 ((cls == CL_RO_WFAULT) && wants_wr));
    assign csr_wr   = wants_wr && !illegal && (cls == CL_STORED);

    // event selection, trap first
    always_comb begin
        if (trap_take)      ev = EV_TRAP;
        else if (mret_take) ev = EV_MRET;
        else if (csr_wr)    ev = EV_CSR;
        else                ev = EV_IDLE;
    end

    // read view of the selected register
    always_comb begin
        old_val = '0;
        unique case (sel)
            SEL_STATUS: begin
                old_val[B_MIE]           = sts_mie;
                old_val[B_MPIE]          = sts_mpie;
                old_val[B_MPP_H:B_MPP_L] = 2'b11;
            end
            SEL_IE:      old_val[B_MEX] = ie_mex;
            SEL_IP:      old_val[B_MEX] = ext_irq;
            SEL_TVEC:    old_val = {tvec_q, 2'b00};
            SEL_SCRATCH: old_val = scratch_q;
            SEL_EPC:     old_val = {epc_q, 2'b00};
            SEL_CAUSE: begin
                old_val[XLEN-1]     = cause_irq_q;
                old_val[CODE_W-1:0] = cause_code_q;
            end
            SEL_ZERO:    old_val = '0;
        endcase
    end

    // write value
    always_comb begin
        unique case (op)
            OP_RW:   wval = csr_wdata;
            OP_SET:  wval = old_val | csr_wdata;
            OP_CLR:  wval = old_val & ~csr_wdata;
            OP_NONE: wval = old_val;
        endcase
    end

    mtrap_status u_sts (
        .clk    (clk),
        .rst_n  (rst_n),
        .ev     (ev),
        .sel    (sel),
        .wval   (wval),
        .mie_q  (sts_mie),
        .mpie_q (sts_mpie),
        .meie_q (ie_mex)
    );

    mtrap_store u_sto (
        .clk          (clk),
        .rst_n        (rst_n),
        .ev           (ev),
        .sel          (sel),
        .wval         (wval),
        .trap_irq     (trap_irq),
        .trap_code    (trap_code),
        .trap_pc      (trap_pc),
        .scratch_q    (scratch_q),
        .epc_q        (epc_q),
        .tvec_q       (tvec_q),
        .cause_irq_q  (cause_irq_q),
        .cause_code_q (cause_code_q)
    );

    assign rdata       = (access && csr_rd && !illegal) ? old_val : '0;
    assign irq_pending = ext_irq && ie_mex && sts_mie;
    assign trap_vec    = {tvec_q, 2'b00};
    assign ret_pc      = {epc_q, 2'b00};
endmodule

// File: rtl/mtrap_csr_chk.sv
module mtrap_csr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trap_take,
    input logic        mret_take,
    input logic [31:0] trap_pc,
    input logic        ext_irq,
    input logic        illegal,
    input logic        irq_pending,
    input logic [31:0] rdata,
    input logic [31:0] trap_vec,
    input logic [31:0] ret_pc,
    input logic        sts_mie,
    input logic        sts_mpie
);
    // R12
    trap_epc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> ret_pc == {$past(trap_pc[31:2]), 2'b00});

    // R12
    trap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !irq_pending);

    // R13
    mret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mret_take && !trap_take) |=> (sts_mie == $past(sts_mpie)) && sts_mpie);

    // R11
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (illegal && !trap_take && !mret_take) |=> $stable(trap_vec) && $stable(ret_pc));

    // R11
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> rdata == 32'h0);

    // R14
    pend_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ext_irq);
endmodule

bind mtrap_csr mtrap_csr_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trap_take   (trap_take),
    .mret_take   (mret_take),
    .trap_pc     (trap_pc),
    .ext_irq     (ext_irq),
    .illegal     (illegal),
    .irq_pending (irq_pending),
    .rdata       (rdata),
    .trap_vec    (trap_vec),
    .ret_pc      (ret_pc),
    .sts_mie     (sts_mie),
    .sts_mpie    (sts_mpie)
);

// File: tb/mtrap_csr_bench.sv
`timescale 1ns/1ps
module mtrap_csr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] csr_addr = '0;
    logic [1:0]  csr_op = '0;
    logic        csr_rd = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        ext_irq = 1'b0;
    logic        trap_take = 1'b0;
    logic        trap_irq = 1'b0;
    logic [3:0]  trap_code = '0;
    logic [31:0] trap_pc = '0;
    logic        mret_take = 1'b0;
    logic [31:0] rdata, trap_vec, ret_pc;
    logic        illegal, irq_pending;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mtrap_csr u_mtrap_csr (.*);

    typedef struct packed {
        logic [1:0]  op;
        logic        rd;
        logic [11:0] addr;
        logic [31:0] wd;
        logic [31:0] exp;
        logic        ill;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 32;
    localparam vec_t VT [NV] = '{
        '{2'd1, 1'b1, 12'h340, 32'hDEADBEEF, 32'h0000_0000, 1'b0, 4'd2},  // R2 replace
        '{2'd2, 1'b1, 12'h340, 32'h0000_0000, 32'hDEADBEEF, 1'b0, 4'd2},  // R2 readback
        '{2'd3, 1'b1, 12'h340, 32'h0000_FFFF, 32'hDEADBEEF, 1'b0, 4'd2},  // R2 clear
        '{2'd2, 1'b1, 12'h340, 32'h0000_0011, 32'hDEAD0000, 1'b0, 4'd2},  // R2 set
        '{2'd2, 1'b1, 12'h340, 32'h0000_0000, 32'hDEAD0011, 1'b0, 4'd3},  // R3 zero set
        '{2'd1, 1'b1, 12'h305, 32'h1234_5679, 32'h0000_0000, 1'b0, 4'd6},  // R6
        '{2'd2, 1'b1, 12'h305, 32'h0000_0000, 32'h1234_5678, 1'b0, 4'd6},  // R6 mode 0
        '{2'd1, 1'b1, 12'h300, 32'hFFFF_FFFF, 32'h0000_1800, 1'b0, 4'd4},  // R4
        '{2'd2, 1'b1, 12'h300, 32'h0000_0000, 32'h0000_1888, 1'b0, 4'd4},  // R4
        '{2'd3, 1'b1, 12'h300, 32'h0000_0008, 32'h0000_1888, 1'b0, 4'd4},  // R4
        '{2'd1, 1'b1, 12'h304, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd4},  // R4
        '{2'd2, 1'b1, 12'h304, 32'h0000_0000, 32'h0000_0800, 1'b0, 4'd4},  // R4
        '{2'd2, 1'b1, 12'h344, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd5},  // R5
        '{2'd1, 1'b1, 12'h344, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd5},  // R5
        '{2'd2, 1'b1, 12'hF11, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd9},  // R9 read ok
        '{2'd1, 1'b1, 12'hF14, 32'h0000_0005, 32'h0000_0000, 1'b1, 4'd9},  // R9
        '{2'd2, 1'b1, 12'hF12, 32'h0000_0001, 32'h0000_0000, 1'b1, 4'd9},  // R9
        '{2'd1, 1'b1, 12'h301, 32'hFFFF_FFFF, 32'h0000_0000, 1'b0, 4'd10}, // R10
        '{2'd1, 1'b1, 12'hB10, 32'h0000_0055, 32'h0000_0000, 1'b0, 4'd10}, // R10
        '{2'd2, 1'b1, 12'h33F, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd10}, // R10
        '{2'd2, 1'b1, 12'h302, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'd11}, // R11
        '{2'd2, 1'b1, 12'h7C0, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'd11}, // R11
        '{2'd2, 1'b1, 12'hB01, 32'h0000_0000, 32'h0000_0000, 1'b1, 4'd11}, // R11
        '{2'd1, 1'b1, 12'h342, 32'h0000_000B, 32'h0000_0000, 1'b0, 4'd8},  // R8
        '{2'd1, 1'b1, 12'h342, 32'h0000_0005, 32'h0000_000B, 1'b0, 4'd8},  // R8 rejected
        '{2'd1, 1'b1, 12'h342, 32'h8000_000B, 32'h0000_000B, 1'b0, 4'd8},  // R8
        '{2'd2, 1'b1, 12'h342, 32'h0000_0000, 32'h8000_000B, 1'b0, 4'd8},  // R8
        '{2'd1, 1'b1, 12'h341, 32'h0000_1003, 32'h0000_0000, 1'b0, 4'd7},  // R7
        '{2'd2, 1'b1, 12'h341, 32'h0000_0000, 32'h0000_1000, 1'b0, 4'd7},  // R7
        '{2'd1, 1'b0, 12'h340, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd2},  // R2 no read
        '{2'd2, 1'b1, 12'h340, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd2},  // R2
        '{2'd0, 1'b1, 12'h302, 32'h0000_0000, 32'h0000_0000, 1'b0, 4'd11}  // R11 idle
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] op, input logic rd, input logic [11:0] a,
                         input logic [31:0] wd);
        @(negedge clk);
        csr_op = op; csr_rd = rd; csr_addr = a; csr_wdata = wd;
        trap_take = 1'b0; mret_take = 1'b0;
        #1;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        drive(2'd2, 1'b1, a, 32'h0);
        check(req, rdata, exp);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd_chk("R1 status", 12'h300, 32'h0000_1800);
        rd_chk("R1 scratch", 12'h340, 32'h0);
        rd_chk("R1 tvec", 12'h305, 32'h0);
        rd_chk("R1 cause", 12'h342, 32'h0);
        check("R1 pending", {31'b0, irq_pending}, 32'h0);
        check("R1 ret_pc", ret_pc, 32'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VT[i].op, VT[i].rd, VT[i].addr, VT[i].wd);
            check($sformatf("R%0d vec%0d rdata", VT[i].req, i), rdata, VT[i].exp);
            check($sformatf("R%0d vec%0d illegal", VT[i].req, i), {31'b0, illegal},
                  {31'b0, VT[i].ill});
        end
        // state now: status 1880, ie 800, tvec 12345678, epc 1000, scratch 0
        check("R6 trap_vec", trap_vec, 32'h1234_5678);
        check("R7 ret_pc", ret_pc, 32'h0000_1000);

        // R5 / R14 external line
        @(negedge clk); ext_irq = 1'b1;
        rd_chk("R5 meip", 12'h344, 32'h0000_0800);
        check("R14 masked by MIE", {31'b0, irq_pending}, 32'h0);
        drive(2'd2, 1'b0, 12'h300, 32'h0000_0008);
        drive(2'd0, 1'b0, 12'h000, 32'h0);
        check("R14 pending", {31'b0, irq_pending}, 32'h1);

        // R12 trap entry beats a concurrent CSR write
        @(negedge clk);
        csr_op = 2'd1; csr_rd = 1'b0; csr_addr = 12'h340; csr_wdata = 32'h0000_AAAA;
        trap_take = 1'b1; trap_irq = 1'b0; trap_code = 4'd3; trap_pc = 32'h0000_2006;
        drive(2'd0, 1'b0, 12'h000, 32'h0);
        check("R12 ret_pc", ret_pc, 32'h0000_2004);
        check("R12 masked", {31'b0, irq_pending}, 32'h0);
        rd_chk("R12 cause", 12'h342, 32'h0000_0003);
        rd_chk("R12 status", 12'h300, 32'h0000_1880);
        rd_chk("R12 write dropped", 12'h340, 32'h0);

        // R13 return beats a concurrent status write
        @(negedge clk);
        csr_op = 2'd1; csr_rd = 1'b0; csr_addr = 12'h300; csr_wdata = 32'h0;
        mret_take = 1'b1;
        rd_chk("R13 status", 12'h300, 32'h0000_1888);
        check("R13 pending", {31'b0, irq_pending}, 32'h1);

        // R12 trap wins over simultaneous return
        @(negedge clk);
        csr_op = 2'd0; trap_take = 1'b1; mret_take = 1'b1;
        trap_irq = 1'b1; trap_code = 4'd11; trap_pc = 32'h0000_3000;
        rd_chk("R12 irq cause", 12'h342, 32'h8000_000B);
        rd_chk("R12 priority status", 12'h300, 32'h0000_1880);
        check("R12 ret_pc2", ret_pc, 32'h0000_3000);

        // R13 MPIE=0 case
        drive(2'd3, 1'b0, 12'h300, 32'h0000_0080);
        @(negedge clk); csr_op = 2'd0; mret_take = 1'b1;
        rd_chk("R13 mpie0", 12'h300, 32'h0000_1880);
        check("R14 off", {31'b0, irq_pending}, 32'h0);

        @(negedge clk); ext_irq = 1'b0;
        rd_chk("R5 meip low", 12'h344, 32'h0);

        // R1 reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1 status after reset", 12'h300, 32'h0000_1800);
        rd_chk("R1 ie after reset", 12'h304, 32'h0);
        check("R1 trap_vec after reset", trap_vec, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule